// File: doc/BRIEF.md
# Sleep Mode and Clock-Gating Controller

This controller decides which clock domains of a small processor-style core are running. While the core is active, software selects a sleep mode with a 3-bit code, arms it with a sleep-enable bit, and then issues a one-cycle sleep request. The controller then parks in idle, power-down, power-save or standby. Each mode keeps a different set of domain enables alive: core, I/O, main oscillator and timer. Each mode also accepts a different set of wake sources. Gated clocks are represented as enable outputs.

Returning to active depends on the mode. Idle resumes on the next edge. Standby waits a fixed six cycles because its oscillator never stopped. Power-down and power-save wait a start-up delay, chosen by a 2-bit field, so that the restarted oscillator can settle. Any of the three reset-type wake sources jumps straight back to active from any state, including an unfinished start-up wait.

A per-peripheral cut vector gates individual peripheral clocks. It only matters while the I/O domain runs, that is in active and idle.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: After rst_n is released the controller is active: clk_en_core, clk_en_io, clk_en_osc and clk_en_tmr are all 1 and resume is 0.
- R2: A sleep request while sleep_en is 0 is ignored, and every domain enable stays 1.
- R3: Mode code 000 selects idle, and codes 001, 100, 101 and 111 behave as idle. In idle, clk_en_core is 0 while clk_en_io, clk_en_osc and clk_en_tmr are 1.
- R4: Mode code 010 selects power-down, and so does code 110 when osc_xtal is 0. In power-down all four domain enables are 0.
- R5: Mode code 011 selects power-save. In power-save only clk_en_tmr may be 1, and it equals tmr_en.
- R6: Mode code 110 with osc_xtal at 1 selects standby. In standby only clk_en_osc is 1.
- R7: In power-down and standby, wk_start_det, wk_lvl_irq and wk_pin_chg wake the device. Timer events do not wake it, whatever the enables.
- R8: A timer event wakes the device from power-save or idle only when tmr_en and irq_glob_en are set, together with tmr_ovf_ie for tmr_ovf or tmr_cmp_ie for tmr_cmp.
- R9: Counting the edge that samples the wake as the first, clk_en_core returns on edge 1 from idle, on edge 7 from standby, and on edge N+1 from power-down or power-save. N is 6, 1024, 16384 or 65536 for sut_sel values 0 to 3. During the wait, clk_en_osc is 1 and clk_en_core is 0.
- R10: Any of wk_ext_rst, wk_wdt_rst or wk_bor_rst returns the controller to active on the next edge. This holds from any sleep state or start-up wait, regardless of interrupt enables.
- R11: If a wake source allowed in the requested mode is present on the same edge as the sleep request, entry is aborted and the controller stays active.
- R12: periph_clk_en[i] equals the inverse of pwr_cut[i] in active and idle, and is 0 in every other state.
- R13: resume is a one-cycle pulse on the first cycle back in active after any sleep state or start-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_en | input | 1 | Arms sleep requests |
| sleep_req | input | 1 | One-cycle sleep request |
| mode_sel | input | 3 | Sleep mode code |
| osc_xtal | input | 1 | Strap: 1 = external crystal/resonator |
| sut_sel | input | 2 | Start-up delay select |
| wk_ext_rst | input | 1 | External reset wake |
| wk_wdt_rst | input | 1 | Watchdog reset wake |
| wk_bor_rst | input | 1 | Brown-out reset wake |
| wk_start_det | input | 1 | Serial start-condition wake |
| wk_lvl_irq | input | 1 | Level interrupt wake |
| wk_pin_chg | input | 1 | Pin-change wake |
| tmr_en | input | 1 | Timer domain enabled |
| tmr_ovf | input | 1 | Timer overflow event |
| tmr_cmp | input | 1 | Timer compare event |
| tmr_ovf_ie | input | 1 | Overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Compare interrupt enable |
| irq_glob_en | input | 1 | Global interrupt enable |
| pwr_cut | input | NPERIPH | Per-peripheral clock cut (1 = stopped) |
| clk_en_core | output | 1 | Core clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_osc | output | 1 | Main oscillator enable |
| clk_en_tmr | output | 1 | Timer domain clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| resume | output | 1 | Pulse on return to active |

## Verification
The assertions assume that every wake and timer event input is sampled synchronously to clk and is stable around the edge. They also assume that sleep_en is held steady whenever a request is made. The bench changes every input one time unit after a rising edge and holds event inputs for exactly one cycle. It clears events before the next request, so aborts happen only where a test intends them. The longest start-up setting is never waited out, so the run stays short.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE, ST_IDLE, ST_PDOWN, ST_PSAVE, ST_STBY, ST_WAKE
  } slp_state_e;

  typedef struct packed {
    logic core;
    logic io;
    logic osc;
    logic tmr;
  } dom_en_t;

  // Mode code to parked state; undefined codes fall back to idle.
  function automatic slp_state_e decode_mode(input logic [2:0] code, input logic xtal);
    case (code)
      3'b010:  return ST_PDOWN;
      3'b011:  return ST_PSAVE;
      3'b110:  return xtal ? ST_STBY : ST_PDOWN;
      default: return ST_IDLE;
    endcase
  endfunction

  // Domain enables implied by a state.
  function automatic dom_en_t domains_for(input slp_state_e st, input logic tmr_on);
    dom_en_t d;
    d = '0;
    case (st)
      ST_ACTIVE: d = '{core: 1'b1, io: 1'b1, osc: 1'b1, tmr: 1'b1};
      ST_IDLE:   d = '{core: 1'b0, io: 1'b1, osc: 1'b1, tmr: 1'b1};
      ST_PSAVE:  d.tmr = tmr_on;
      ST_STBY:   d.osc = 1'b1;
      ST_WAKE:   d.osc = 1'b1;
      default:   d = '0;
    endcase
    return d;
  endfunction

  // Whether the qualified sources may leave (or prevent entry into) a state.
  function automatic logic wake_ok(input slp_state_e st, input logic rst_hit,
                                   input logic async_hit, input logic tmr_hit);
    case (st)
      ST_IDLE:          return rst_hit | async_hit | tmr_hit;
      ST_PSAVE:         return rst_hit | async_hit | tmr_hit;
      ST_PDOWN, ST_STBY: return rst_hit | async_hit;
      ST_WAKE:          return rst_hit;
      default:          return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual (
  input  logic wk_ext_rst,
  input  logic wk_wdt_rst,
  input  logic wk_bor_rst,
  input  logic wk_start_det,
  input  logic wk_lvl_irq,
  input  logic wk_pin_chg,
  input  logic tmr_en,
  input  logic tmr_ovf,
  input  logic tmr_cmp,
  input  logic tmr_ovf_ie,
  input  logic tmr_cmp_ie,
  input  logic irq_glob_en,
  output logic rst_hit,
  output logic async_hit,
  output logic tmr_hit
);
  assign rst_hit   = wk_ext_rst | wk_wdt_rst | wk_bor_rst;
  assign async_hit = wk_start_det | wk_lvl_irq | wk_pin_chg;
  assign tmr_hit   = tmr_en & irq_glob_en &
                     ((tmr_ovf & tmr_ovf_ie) | (tmr_cmp & tmr_cmp_ie));
endmodule

// File: rtl/slp_startup_cnt.sv
module slp_startup_cnt #(
  parameter int SUT_D0   = 6,
  parameter int SUT_D1   = 1024,
  parameter int SUT_D2   = 16384,
  parameter int SUT_D3   = 65536,
  parameter int STBY_CYC = 6,
  parameter int CW       = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       use_stby,
  input  logic [1:0] sut_sel,
  input  logic       run,
  output logic       done
);
  logic [CW-1:0] cnt;

  function automatic int wait_len(input logic stby, input logic [1:0] sel);
    if (stby) return STBY_CYC;
    case (sel)
      2'd0:    return SUT_D0;
      2'd1:    return SUT_D1;
      2'd2:    return SUT_D2;
      default: return SUT_D3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= CW'(wait_len(use_stby, sut_sel) - 1);
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/slp_periph_gate.sv
module slp_periph_gate #(
  parameter int NPERIPH = 8
) (
  input  logic               io_on,
  input  logic [NPERIPH-1:0] pwr_cut,
  output logic [NPERIPH-1:0] periph_clk_en
);
  for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
    assign periph_clk_en[i] = io_on & ~pwr_cut[i];
  end
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import slp_pkg::*;
#(
  parameter int NPERIPH  = 8,
  parameter int SUT_D0   = 6,
  parameter int SUT_D1   = 1024,
  parameter int SUT_D2   = 16384,
  parameter int SUT_D3   = 65536,
  parameter int STBY_CYC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_en,
  input  logic               sleep_req,
  input  logic [2:0]         mode_sel,
  input  logic               osc_xtal,
  input  logic [1:0]         sut_sel,
  input  logic               wk_ext_rst,
  input  logic               wk_wdt_rst,
  input  logic               wk_bor_rst,
  input  logic               wk_start_det,
  input  logic               wk_lvl_irq,
  input  logic               wk_pin_chg,
  input  logic               tmr_en,
  input  logic               tmr_ovf,
  input  logic               tmr_cmp,
  input  logic               tmr_ovf_ie,
  input  logic               tmr_cmp_ie,
  input  logic               irq_glob_en,
  input  logic [NPERIPH-1:0] pwr_cut,
  output logic               clk_en_core,
  output logic               clk_en_io,
  output logic               clk_en_osc,
  output logic               clk_en_tmr,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               resume
);
  localparam int MAXA = (SUT_D0 > SUT_D1) ? SUT_D0 : SUT_D1;
  localparam int MAXB = (SUT_D2 > SUT_D3) ? SUT_D2 : SUT_D3;
  localparam int MAXC = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAXD = (MAXC > STBY_CYC) ? MAXC : STBY_CYC;
  localparam int CW   = $clog2(MAXD + 1);

  slp_state_e st, nxt, tgt;
  dom_en_t    dom;
  logic rst_hit, async_hit, tmr_hit;
  logic cnt_load, cnt_stby, cnt_done, in_startup;
  logic entry_abort, enter_sleep;
  logic resume_q;

  slp_wake_qual u_qual (
    .wk_ext_rst(wk_ext_rst), .wk_wdt_rst(wk_wdt_rst), .wk_bor_rst(wk_bor_rst),
    .wk_start_det(wk_start_det), .wk_lvl_irq(wk_lvl_irq), .wk_pin_chg(wk_pin_chg),
    .tmr_en(tmr_en), .tmr_ovf(tmr_ovf), .tmr_cmp(tmr_cmp),
    .tmr_ovf_ie(tmr_ovf_ie), .tmr_cmp_ie(tmr_cmp_ie), .irq_glob_en(irq_glob_en),
    .rst_hit(rst_hit), .async_hit(async_hit), .tmr_hit(tmr_hit)
  );

  assign tgt        = decode_mode(mode_sel, osc_xtal);
  assign in_startup = (st == ST_WAKE);

  always_comb begin
    nxt         = st;
    cnt_load    = 1'b0;
    cnt_stby    = 1'b0;
    entry_abort = 1'b0;
    enter_sleep = 1'b0;
    case (st)
      ST_ACTIVE: begin
        if (sleep_req && sleep_en) begin
          if (wake_ok(tgt, rst_hit, async_hit, tmr_hit)) begin
            entry_abort = 1'b1;
          end else begin
            enter_sleep = 1'b1;
            nxt         = tgt;
          end
        end
      end
      ST_WAKE: begin
        if (rst_hit || cnt_done) nxt = ST_ACTIVE;
      end
      default: begin
        if (wake_ok(st, rst_hit, async_hit, tmr_hit)) begin
          if (rst_hit || st == ST_IDLE) begin
            nxt = ST_ACTIVE;
          end else begin
            nxt      = ST_WAKE;
            cnt_load = 1'b1;
            cnt_stby = (st == ST_STBY);
          end
        end
      end
    endcase
  end

  slp_startup_cnt #(
    .SUT_D0(SUT_D0), .SUT_D1(SUT_D1), .SUT_D2(SUT_D2), .SUT_D3(SUT_D3),
    .STBY_CYC(STBY_CYC), .CW(CW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .use_stby(cnt_stby),
    .sut_sel(sut_sel), .run(in_startup), .done(cnt_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_ACTIVE;
      resume_q <= 1'b0;
    end else begin
      st       <= nxt;
      resume_q <= (nxt == ST_ACTIVE) && (st != ST_ACTIVE);
    end
  end

  assign dom         = domains_for(st, tmr_en);
  assign clk_en_core = dom.core;
  assign clk_en_io   = dom.io;
  assign clk_en_osc  = dom.osc;
  assign clk_en_tmr  = dom.tmr;
  assign resume      = resume_q;

  slp_periph_gate #(.NPERIPH(NPERIPH)) u_gate (
    .io_on(dom.io), .pwr_cut(pwr_cut), .periph_clk_en(periph_clk_en)
  );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter int NPERIPH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_en,
  input logic               clk_en_core,
  input logic               clk_en_io,
  input logic               clk_en_osc,
  input logic [NPERIPH-1:0] periph_clk_en,
  input logic               resume,
  input logic               rst_hit,
  input logic               entry_abort,
  input logic               in_startup
);
  a_r10_rst_wake: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> clk_en_core);
  a_r2_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_core && !sleep_en) |=> clk_en_core);
  a_r11_abort_stays: assert property (@(posedge clk) disable iff (!rst_n)
    entry_abort |=> clk_en_core);
  a_r12_gate_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_clk_en) |-> clk_en_io);
  a_r13_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  a_r13_resume_core: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> clk_en_core);
  a_r9_startup_osc: assert property (@(posedge clk) disable iff (!rst_n)
    in_startup |-> (clk_en_osc && !clk_en_core));
  a_r6_osc_under_core: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_osc |-> !clk_en_core);
endmodule

bind sleep_clkgate_ctrl slp_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en),
  .clk_en_core(clk_en_core), .clk_en_io(clk_en_io), .clk_en_osc(clk_en_osc),
  .periph_clk_en(periph_clk_en), .resume(resume),
  .rst_hit(rst_hit), .entry_abort(entry_abort), .in_startup(in_startup)
);

// File: tb/sleep_clkgate_ctrl_tb.sv
module sleep_clkgate_ctrl_tb;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 0, sleep_req = 0, osc_xtal = 0;
  logic [2:0] mode_sel = 0;
  logic [1:0] sut_sel = 0;
  logic wk_ext_rst = 0, wk_wdt_rst = 0, wk_bor_rst = 0;
  logic wk_start_det = 0, wk_lvl_irq = 0, wk_pin_chg = 0;
  logic tmr_en = 0, tmr_ovf = 0, tmr_cmp = 0, tmr_ovf_ie = 0, tmr_cmp_ie = 0, irq_glob_en = 0;
  logic [NP-1:0] pwr_cut = '0;
  logic clk_en_core, clk_en_io, clk_en_osc, clk_en_tmr, resume;
  logic [NP-1:0] periph_clk_en;

  int nchk = 0, nerr = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sleep_clkgate_ctrl #(.NPERIPH(NP)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 active, 1 idle, 2 power-down, 3 power-save, 4 standby, 5 start-up wait
  int m_st = 0, m_rem = 0, m_nx = 0, m_tg = 0;
  bit m_res = 0, rsth, asy, tmh;

  function automatic int target_of(input logic [2:0] m, input logic x);
    if (m == 3'b010) return 2;
    if (m == 3'b011) return 3;
    if (m == 3'b110) return x ? 4 : 2;
    return 1;
  endfunction

  function automatic int settle_len(input logic [1:0] s);
    return (s == 0) ? 6 : (s == 1) ? 1024 : (s == 2) ? 16384 : 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_res = 0;
    end else begin
      rsth = wk_ext_rst | wk_wdt_rst | wk_bor_rst;
      asy  = wk_start_det | wk_lvl_irq | wk_pin_chg;
      tmh  = tmr_en && irq_glob_en && ((tmr_ovf && tmr_ovf_ie) || (tmr_cmp && tmr_cmp_ie));
      m_nx = m_st;
      if (m_st == 0) begin
        if (sleep_req && sleep_en) begin
          m_tg = target_of(mode_sel, osc_xtal);
          if (!(rsth || asy || (tmh && (m_tg == 1 || m_tg == 3)))) m_nx = m_tg;
        end
      end else if (rsth) begin
        m_nx = 0;
      end else if (m_st == 1) begin
        if (asy || tmh) m_nx = 0;
      end else if (m_st == 5) begin
        if (m_rem == 1) m_nx = 0; else m_rem = m_rem - 1;
      end else if (asy || (m_st == 3 && tmh)) begin
        m_nx = 5;
        m_rem = (m_st == 4) ? 6 : settle_len(sut_sel);
      end
      m_res = (m_nx == 0) && (m_st != 0);
      m_st = m_nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ec, ei, eo, et;
      logic [NP-1:0] ep;
      ec = (m_st == 0);
      ei = (m_st <= 1);
      eo = (m_st <= 1) || (m_st >= 4);
      et = (m_st <= 1) || (m_st == 3 && tmr_en);
      ep = ei ? ~pwr_cut : '0;
      chk(clk_en_core == ec, "R9 core enable vs model", clk_en_core, ec);
      chk(clk_en_io == ei, "R3 io enable vs model", clk_en_io, ei);
      chk(clk_en_osc == eo, "R6 osc enable vs model", clk_en_osc, eo);
      chk(clk_en_tmr == et, "R5 timer enable vs model", clk_en_tmr, et);
      chk(periph_clk_en == ep, "R12 peripheral enables vs model", periph_clk_en, ep);
      chk(resume == m_res, "R13 resume vs model", resume, m_res);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_events();
    wk_ext_rst = 0; wk_wdt_rst = 0; wk_bor_rst = 0;
    wk_start_det = 0; wk_lvl_irq = 0; wk_pin_chg = 0;
    tmr_ovf = 0; tmr_cmp = 0;
  endtask

  task automatic enter(input logic [2:0] m);
    mode_sel = m; sleep_req = 1; tick(); sleep_req = 0;
  endtask

  // Events must be set before calling; returns edges until core enable returns.
  task automatic measure(output int n);
    n = 0;
    do begin
      tick(); clear_events(); n++;
    end while (!clk_en_core && n < 70000);
  endtask

  function automatic int doms();
    return {clk_en_core, clk_en_io, clk_en_osc, clk_en_tmr};
  endfunction

  int lat;

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(doms() == 4'b1111 && !resume, "R1 reset state", doms(), 15);

    // R2: disarmed request
    sleep_en = 0; enter(3'b010); tick();
    chk(doms() == 4'b1111, "R2 request without sleep_en", doms(), 15);
    sleep_en = 1;

    // R3: idle and undefined codes
    enter(3'b000);
    chk(doms() == 4'b0111, "R3 idle domains", doms(), 7);
    wk_pin_chg = 1; measure(lat);
    chk(lat == 1, "R9 idle wake latency", lat, 1);
    chk(resume == 1, "R13 resume after idle", resume, 1);
    tick();
    chk(resume == 0, "R13 resume one cycle", resume, 0);
    enter(3'b101);
    chk(doms() == 4'b0111, "R3 undefined code as idle", doms(), 7);
    tmr_en = 1; irq_glob_en = 1; tmr_ovf_ie = 1; tmr_ovf = 1; measure(lat);
    chk(lat == 1, "R8 timer wakes idle", lat, 1);

    // R4 / R7: power-down ignores timer, wakes on start detect
    sut_sel = 0; enter(3'b010);
    chk(doms() == 4'b0000, "R4 power-down domains", doms(), 0);
    tmr_ovf = 1; tick(); clear_events(); tick();
    chk(doms() == 4'b0000, "R7 timer ignored in power-down", doms(), 0);
    wk_start_det = 1; tick(); clear_events();
    chk(clk_en_osc == 1 && clk_en_core == 0, "R9 start-up osc on core off", doms(), 2);
    measure(lat);
    chk(lat + 1 == 7, "R9 power-down sut 0 latency", lat + 1, 7);

    sut_sel = 1; enter(3'b010);
    wk_lvl_irq = 1; measure(lat);
    chk(lat == 1025, "R9 power-down sut 1 latency", lat, 1025);

    // R4: 110 without crystal strap
    osc_xtal = 0; enter(3'b110);
    chk(doms() == 4'b0000, "R4 code 110 without strap", doms(), 0);
    wk_pin_chg = 1; measure(lat);
    chk(lat == 1025, "R7 pin change wakes power-down", lat, 1025);

    // R6: standby ignores sut_sel
    osc_xtal = 1; sut_sel = 3; enter(3'b110);
    chk(doms() == 4'b0010, "R6 standby domains", doms(), 2);
    wk_start_det = 1; measure(lat);
    chk(lat == 7, "R9 standby latency", lat, 7);

    // R5 / R8: power-save
    sut_sel = 2; irq_glob_en = 0; enter(3'b011);
    chk(doms() == 4'b0001, "R5 power-save domains", doms(), 1);
    tmr_ovf = 1; tick(); clear_events(); tick();
    chk(clk_en_core == 0, "R8 no wake without global enable", clk_en_core, 0);
    irq_glob_en = 1; tmr_ovf_ie = 0; tmr_cmp_ie = 0;
    tmr_ovf = 1; tmr_cmp = 1; tick(); clear_events(); tick();
    chk(clk_en_core == 0, "R8 no wake without source enable", clk_en_core, 0);
    tmr_en = 0; tick();
    chk(clk_en_tmr == 0, "R5 timer enable follows tmr_en", clk_en_tmr, 0);
    tmr_en = 1; tmr_cmp_ie = 1; tmr_cmp = 1; measure(lat);
    chk(lat == 16385, "R8 compare wake with sut 2", lat, 16385);

    // R10: reset wakes with enables cleared
    irq_glob_en = 0; tmr_cmp_ie = 0; sut_sel = 1;
    enter(3'b010);
    wk_wdt_rst = 1; measure(lat);
    chk(lat == 1, "R10 watchdog reset from power-down", lat, 1);
    enter(3'b010);
    wk_pin_chg = 1; tick(); clear_events();
    repeat (10) tick();
    wk_bor_rst = 1; measure(lat);
    chk(lat == 1 && resume, "R10 brown-out aborts start-up", lat, 1);

    // R11: abort on simultaneous wake
    tick();
    wk_pin_chg = 1; enter(3'b010); clear_events();
    chk(doms() == 4'b1111 && !resume, "R11 entry aborted", doms(), 15);

    // R12: peripheral gating
    pwr_cut = 8'b0101_0011; tick();
    chk(periph_clk_en == 8'b1010_1100, "R12 gating in active", periph_clk_en, 8'hAC);
    enter(3'b000);
    chk(periph_clk_en == 8'b1010_1100, "R12 gating in idle", periph_clk_en, 8'hAC);
    wk_ext_rst = 1; measure(lat);
    enter(3'b011);
    chk(periph_clk_en == 8'h00, "R12 all off in power-save", periph_clk_en, 0);
    wk_ext_rst = 1; measure(lat);
    repeat (3) tick();

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nerr++;
      $display("FAIL watchdog R9: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule